// File: doc/BRIEF.md
# Stream Address Generator

This block serves one port of a scratch-pad SRAM. Before a loop-heavy code section, four access-pattern descriptors are written into it through a 32-bit descriptor write port. After that, each load/store request names one descriptor and gets back an SRAM word address. The block needs no help from an ALU to produce it. The address is built from two loop counters, which it selects from the loop unit's counter bus. Each counter is shifted by a power-of-two stride, the two results are ORed, and the descriptor's base is added.

A request can adjust this in three ways:
- It can replace the inner counter with an unroll factor taken from the instruction.
- It can subtract a modulo-period tag from the inner counter. Iterations of a software-pipelined loop that are still in flight then see their own index, with no rotating register file.
- It can hand in an ALU-computed offset. The offset replaces the shift/OR term and is still added to the base, which covers indirect streams of the form A[B[i]].

A pipeline register sits in front of the final add, so the address appears one cycle after the request.

Top module: `sag_top`

## Requirements
- R1: A descriptor word written to slot `ctx_widx_i` while `ctx_we_i` is high is stored at the clock edge. Its fields are: base in bits [13:0], row shift in [17:14], element shift in [21:18], outer-counter index in [24:22] and inner-counter index in [27:25]. Bits [31:28] have no effect on any address.
- R2: In plain mode the address is base + ((outer << row shift) | (inner << element shift)). Bits shifted above bit 13 are dropped, and the sum wraps modulo 2^14.
- R3: Counter index k selects bits [k*9+8 : k*9] of `loop_cnt_i`. Index 0 always reads as zero, whatever is on bits [8:0] of the bus.
- R4: When `req_unroll_en_i` is 1, the 4-bit `req_unroll_i` (zero-extended) is used in place of the inner counter.
- R5: The inner counter minus `req_mod_period_i` (computed modulo 2^9) is used in place of the inner counter. The tag has no effect in unroll mode or ALU mode.
- R6: When `req_alu_en_i` is 1, the address is base + `req_alu_addr_i` (mod 2^14). ALU mode takes priority over unroll mode.
- R7: `addr_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. `addr_o` carries that request's address during that cycle. Back-to-back requests give back-to-back addresses.
- R8: A descriptor write to the same slot in the same cycle as a request does not affect that request. It takes effect from the following request on.
- R9: In a cycle after one with no request, `addr_valid_o` is 0 and `addr_o` keeps its last value, even if descriptors are written in the meantime.
- R10: After reset, `addr_valid_o` is 0, `addr_o` is 0 and all descriptors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_we_i | input | 1 | Descriptor write enable |
| ctx_widx_i | input | 2 | Descriptor slot to write |
| ctx_wdata_i | input | 32 | Packed descriptor word |
| loop_cnt_i | input | 72 | Eight 9-bit loop counters from the loop unit; slot 0 unused |
| req_valid_i | input | 1 | Load/store request present |
| req_ctx_idx_i | input | 2 | Descriptor used by the request |
| req_unroll_en_i | input | 1 | Use the unroll factor as the inner variable |
| req_unroll_i | input | 4 | Unroll factor from the instruction immediate |
| req_mod_period_i | input | 4 | Modulo-period tag subtracted from the inner counter |
| req_alu_en_i | input | 1 | Use the ALU-supplied offset |
| req_alu_addr_i | input | 14 | ALU-computed offset |
| addr_o | output | 14 | SRAM word address |
| addr_valid_o | output | 1 | Address valid, one cycle after a request |

## Verification
The assertions check on every cycle that:
- the valid flag trails the request by exactly one cycle;
- an ALU request's offset reaches the pipeline register unchanged;
- a descriptor write lands in the slot it names;
- the address holds steady while there are no requests.

Only the bench scenarios can show that the arithmetic is right: the shift/OR composition with truncation, wrap of the final add, the zero counter slot, unroll substitution, and modulo compensation that wraps below zero. The same is true of the priority between modes, the read-before-write order of a same-cycle descriptor update, and the reset values.

// File: rtl/sag_pkg.sv
package sag_pkg;
    localparam int ADDR_W  = 14;
    localparam int SH_W    = 4;
    localparam int IDX_W   = 3;
    localparam int CTX_W   = 32;
    localparam int N_CTX   = 4;
    localparam int CNT_W   = 9;
    localparam int UNR_W   = 4;
    localparam int MP_W    = 4;
    localparam int N_CNT   = 1 << IDX_W;
    localparam int CSEL_W  = $clog2(N_CTX);
    localparam int RSV_W   = CTX_W - ADDR_W - 2*SH_W - 2*IDX_W;

    typedef struct packed {
        logic [RSV_W-1:0]  rsv;
        logic [IDX_W-1:0]  inner_idx;
        logic [IDX_W-1:0]  outer_idx;
        logic [SH_W-1:0]   elem_sh;
        logic [SH_W-1:0]   row_sh;
        logic [ADDR_W-1:0] base;
    } desc_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] term;
    } stage_t;
endpackage

// File: rtl/sag_ctx_file.sv
module sag_ctx_file
    import sag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CSEL_W-1:0] widx_i,
    input  logic [CTX_W-1:0]  wdata_i,
    input  logic [CSEL_W-1:0] ridx_i,
    output desc_t             rdata_o
);
    desc_t ctx_d [N_CTX];
    desc_t ctx_q [N_CTX];

    always_comb begin
        for (int k = 0; k < N_CTX; k++) begin
            ctx_d[k] = ctx_q[k];
        end
        if (we_i) begin
            ctx_d[widx_i] = desc_t'(wdata_i);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < N_CTX; k++) begin
            if (!rst_n) ctx_q[k] <= '0;
            else        ctx_q[k] <= ctx_d[k];
        end
    end

    // read happens before the write of the same edge (R8)
    assign rdata_o = ctx_q[ridx_i];

    assert_ctx_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (ctx_q[$past(widx_i)] == desc_t'($past(wdata_i))));
endmodule

// File: rtl/sag_operand_sel.sv
module sag_operand_sel
    import sag_pkg::*;
(
    input  desc_t                  desc_i,
    input  logic [N_CNT*CNT_W-1:0] cnt_i,
    input  logic                   unroll_en_i,
    input  logic [UNR_W-1:0]       unroll_i,
    input  logic [MP_W-1:0]        mod_period_i,
    input  logic                   alu_en_i,
    input  logic [ADDR_W-1:0]      alu_addr_i,
    output logic [ADDR_W-1:0]      term_o
);
    logic [CNT_W-1:0]  outer_v;
    logic [CNT_W-1:0]  inner_v;
    logic [ADDR_W-1:0] outer_sh;
    logic [ADDR_W-1:0] inner_sh;

    always_comb begin
        // counter slot 0 is the constant-zero counter (R3)
        outer_v = '0;
        inner_v = '0;
        if (desc_i.outer_idx != '0) outer_v = cnt_i[desc_i.outer_idx*CNT_W +: CNT_W];
        if (desc_i.inner_idx != '0) inner_v = cnt_i[desc_i.inner_idx*CNT_W +: CNT_W];
        // modulo-period compensation on the inner variable (R5)
        inner_v = inner_v - CNT_W'(mod_period_i);
        // unroll factor replaces the inner variable (R4)
        if (unroll_en_i) inner_v = CNT_W'(unroll_i);
        outer_sh = ADDR_W'(outer_v) << desc_i.row_sh;
        inner_sh = ADDR_W'(inner_v) << desc_i.elem_sh;
        // ALU offset bypasses the shift/OR term (R6)
        term_o = alu_en_i ? alu_addr_i : (outer_sh | inner_sh);
    end
endmodule

// File: rtl/sag_top.sv
module sag_top
    import sag_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctx_we_i,
    input  logic [CSEL_W-1:0]      ctx_widx_i,
    input  logic [CTX_W-1:0]       ctx_wdata_i,
    input  logic [N_CNT*CNT_W-1:0] loop_cnt_i,
    input  logic                   req_valid_i,
    input  logic [CSEL_W-1:0]      req_ctx_idx_i,
    input  logic                   req_unroll_en_i,
    input  logic [UNR_W-1:0]       req_unroll_i,
    input  logic [MP_W-1:0]        req_mod_period_i,
    input  logic                   req_alu_en_i,
    input  logic [ADDR_W-1:0]      req_alu_addr_i,
    output logic [ADDR_W-1:0]      addr_o,
    output logic                   addr_valid_o
);
    desc_t             desc;
    logic [ADDR_W-1:0] term;
    stage_t            stage_d;
    stage_t            stage_q;

    sag_ctx_file u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctx_we_i),
        .widx_i  (ctx_widx_i),
        .wdata_i (ctx_wdata_i),
        .ridx_i  (req_ctx_idx_i),
        .rdata_o (desc)
    );

    sag_operand_sel u_sel (
        .desc_i       (desc),
        .cnt_i        (loop_cnt_i),
        .unroll_en_i  (req_unroll_en_i),
        .unroll_i     (req_unroll_i),
        .mod_period_i (req_mod_period_i),
        .alu_en_i     (req_alu_en_i),
        .alu_addr_i   (req_alu_addr_i),
        .term_o       (term)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = req_valid_i;
        if (req_valid_i) begin
            stage_d.base = desc.base;
            stage_d.term = term;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    // final add after the pipeline register, wraps modulo 2^ADDR_W (R2)
    assign addr_o       = stage_q.base + stage_q.term;
    assign addr_valid_o = stage_q.valid;

    assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> addr_valid_o);
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!addr_valid_o && $stable(addr_o)));
    assert_alu_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_alu_en_i) |=> (stage_q.term == $past(req_alu_addr_i)));
endmodule

// File: tb/sag_top_bench.sv
module sag_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctx_we = 1'b0;
    logic [1:0]  ctx_widx = '0;
    logic [31:0] ctx_wdata = '0;
    logic [71:0] loop_cnt;
    logic        req_valid = 1'b0;
    logic [1:0]  req_ctx = '0;
    logic        req_uen = 1'b0;
    logic [3:0]  req_unr = '0;
    logic [3:0]  req_mp = '0;
    logic        req_aen = 1'b0;
    logic [13:0] req_alu = '0;
    logic [13:0] addr;
    logic        addr_valid;
    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sag_top u_sag_top (
        .clk(clk), .rst_n(rst_n), .ctx_we_i(ctx_we), .ctx_widx_i(ctx_widx),
        .ctx_wdata_i(ctx_wdata), .loop_cnt_i(loop_cnt), .req_valid_i(req_valid),
        .req_ctx_idx_i(req_ctx), .req_unroll_en_i(req_uen), .req_unroll_i(req_unr),
        .req_mod_period_i(req_mp), .req_alu_en_i(req_aen), .req_alu_addr_i(req_alu),
        .addr_o(addr), .addr_valid_o(addr_valid)
    );

    // counters: slot0 junk (must read as zero), 1..7 = 3,5,10,0x1FF,1,2,7
    assign loop_cnt = {9'd7, 9'd2, 9'd1, 9'h1FF, 9'd10, 9'd5, 9'd3, 9'h1FF};

    function automatic logic [31:0] pack(input logic [13:0] b, input logic [3:0] rs,
                                         input logic [3:0] es, input logic [2:0] a,
                                         input logic [2:0] i, input logic [3:0] rsv);
        return {rsv, i, a, es, rs, b};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ctx(input logic [1:0] idx, input logic [31:0] w);
        @(negedge clk);
        ctx_we = 1'b1; ctx_widx = idx; ctx_wdata = w;
        @(negedge clk);
        ctx_we = 1'b0;
    endtask

    task automatic set_req(input logic [39:0] v);
        req_valid = 1'b1;
        {req_ctx, req_uen, req_unr, req_mp, req_aen, req_alu} = v[39:14];
    endtask

    // {ctx, unroll_en, unroll, mod_period, alu_en, alu_addr, expected}
    localparam logic [39:0] VEC [10] = '{
        {2'd0, 1'b0, 4'd0, 4'd0, 1'b0, 14'h0000, 14'h01CA}, // R2 plain
        {2'd1, 1'b0, 4'd0, 4'd0, 1'b0, 14'h0000, 14'h3FFA}, // R3 zero slot
        {2'd2, 1'b0, 4'd0, 4'd0, 1'b0, 14'h0000, 14'h3F6C}, // R2 truncation
        {2'd3, 1'b0, 4'd0, 4'd0, 1'b0, 14'h0000, 14'h0002}, // R2 add wrap
        {2'd0, 1'b0, 4'd0, 4'd2, 1'b0, 14'h0000, 14'h01C6}, // R5 compensation
        {2'd0, 1'b0, 4'd0, 4'd7, 1'b0, 14'h0000, 14'h04FC}, // R5 wrap below zero
        {2'd0, 1'b1, 4'd6, 4'd0, 1'b0, 14'h0000, 14'h01CC}, // R4 unroll
        {2'd0, 1'b1, 4'd6, 4'd2, 1'b0, 14'h0000, 14'h01CC}, // R5 ignored in unroll
        {2'd1, 1'b0, 4'd0, 4'd0, 1'b1, 14'h0123, 14'h0113}, // R6 ALU with wrap
        {2'd2, 1'b1, 4'd1, 4'd3, 1'b1, 14'h0010, 14'h0060}  // R6 ALU over unroll
    };

    initial begin
        #400000;
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid", 32'(addr_valid), 32'd0);
        check("R10 reset addr", 32'(addr), 32'd0);
        rst_n = 1'b1;
        // R10: descriptors zero -> base 0, counters at slot 0 -> address 0
        @(negedge clk); set_req(VEC[0]);
        @(negedge clk); req_valid = 1'b0;
        check("R10 zero descriptor", 32'(addr), 32'd0);

        wr_ctx(2'd0, pack(14'h0100, 4'd6, 4'd1, 3'd1, 3'd2, 4'd0));
        wr_ctx(2'd1, pack(14'h3FF0, 4'd4, 4'd0, 3'd0, 3'd3, 4'd0));
        wr_ctx(2'd2, pack(14'h0050, 4'd8, 4'd2, 3'd4, 3'd7, 4'd0));
        wr_ctx(2'd3, pack(14'h3FFF, 4'd0, 4'd0, 3'd5, 3'd6, 4'hF)); // R1 reserved bits set

        // table walk, back-to-back (R7)
        @(negedge clk); set_req(VEC[0]);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check($sformatf("R7 valid vec%0d", k), 32'(addr_valid), 32'd1);
            check($sformatf("R2/R3/R4/R5/R6 vec%0d", k), 32'(addr), 32'(VEC[k][13:0]));
            if (k < 9) set_req(VEC[k+1]);
            else req_valid = 1'b0;
        end

        // R9: idle with a descriptor write, address holds
        ctx_we = 1'b1; ctx_widx = 2'd2; ctx_wdata = pack(14'h1000, 4'd0, 4'd0, 3'd0, 3'd0, 4'd0);
        @(negedge clk); ctx_we = 1'b0;
        check("R9 valid low", 32'(addr_valid), 32'd0);
        check("R9 addr held", 32'(addr), 32'h0060);
        @(negedge clk);
        check("R9 addr still held", 32'(addr), 32'h0060);

        // R8: same-cycle write to the slot being read
        set_req({2'd0, 1'b0, 4'd0, 4'd0, 1'b0, 14'h0, 14'h0});
        ctx_we = 1'b1; ctx_widx = 2'd0; ctx_wdata = pack(14'h0200, 4'd6, 4'd1, 3'd1, 3'd2, 4'd0);
        @(negedge clk);
        ctx_we = 1'b0;
        check("R8 old descriptor used", 32'(addr), 32'h01CA);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 new descriptor used", 32'(addr), 32'h02CA);
        check("R1 descriptor write", 32'(addr_valid), 32'd1);
        @(negedge clk);
        check("R7 valid drops", 32'(addr_valid), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule